// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming frame, whether it is kept or dropped by looking at its 48-bit destination address. A frame-side strobe delivers the address. One clock later the block returns a done strobe together with an accept flag, and it raises a single-cycle reject event that interrupt logic can collect.

Software sets the filter up through a simple register port with write, read, a 3-bit offset and 32-bit data. The settings are:
- a station (unicast) address;
- a table of group addresses, four entries by default, loaded and inspected through a staged two-word access;
- a mode word with controls that reject group traffic, reject broadcast traffic, or accept everything (promiscuous).

The address is carried little-endian. Address byte 0, the first byte on the wire, sits in `frame_da[7:0]`, and byte 5 sits in `frame_da[47:40]`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every register offset reads 0, every table entry is invalid with a zero address, `frame_done` is low and `reject_evt` is low.
- R2: Offset 1 holds address bytes 0..3, with byte 0 in bits 7:0. Offset 2 holds bytes 4..5 in bits 15:0. A read returns exactly what was written, except that bits 31:16 of offset 2 are not stored and read as 0.
- R3: A frame whose address equals the 48-bit station address `{off2[15:0], off1}` is accepted, whatever the reject controls are set to.
- R4: When bit 31 of the mode word (offset 0) is set, every frame is accepted.
- R5: The all-ones (broadcast) address is accepted while bit 2 of the mode word is 0. It is rejected when bit 2 is 1 and no other rule accepts it.
- R6: A write to offset 4 with bit 23 = 0 commits `{wdata[15:0], offset-3 value}` into the table entry selected by `wdata[17:16]` and marks that entry valid. A frame matching a valid entry is then accepted while bit 1 of the mode word is 0.
- R7: When bit 1 of the mode word is 1, a frame that matches only a table entry is rejected.
- R8: A write to offset 4 with bit 23 = 1 leaves the table unchanged. It copies the selected entry into offset 5 (address bits 31:0) and offset 6 (bits 15:0 = address bits 47:32, bit 31 = entry valid). Offsets 3 and 4 read back their last written values, with offset 4 keeping only bits 23, 17:16 and 15:0.
- R9: A valid all-ones table entry makes broadcast frames be accepted even when bit 2 of the mode word is 1, provided bit 1 is 0.
- R10: `frame_done` pulses for exactly one cycle, in the clock after the cycle in which `frame_valid` is sampled. `reject_evt` pulses in that same cycle when, and only when, the frame is rejected.
- R11: An address that matches neither the station address nor a valid entry, and is not broadcast, is rejected. This includes an address that differs from the station address in one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, 0 when not reading |
| frame_valid | input | 1 | Destination address strobe |
| frame_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_done | output | 1 | Decision strobe, one cycle after `frame_valid` |
| frame_accept | output | 1 | Keep the frame (qualified by `frame_done`) |
| reject_evt | output | 1 | Single-cycle pulse for a rejected frame |

## Verification
The accept path is driven with several kinds of address:
- the exact station address and a copy of it with one bit flipped, to show that a full 48-bit compare is done;
- broadcast, a programmed group address and an unprogrammed group address, to separate the broadcast rule from the table rule;
- an arbitrary unicast address under promiscuous mode, to show that the override beats every other rule.

Each reject control is switched on while the other rules stay fixed, so that a wrong bit position or a swapped control shows up as a changed decision. Table reads of a written entry and of a never-written entry separate the valid flag from the stored address. A read request carrying different upper bits checks that a read does not overwrite the entry.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam int REG_AW = 3;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] OFS_MODE  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_UC_LO = 3'd1;
  localparam logic [REG_AW-1:0] OFS_UC_HI = 3'd2;
  localparam logic [REG_AW-1:0] OFS_MT_LO = 3'd3;
  localparam logic [REG_AW-1:0] OFS_MT_HI = 3'd4;
  localparam logic [REG_AW-1:0] OFS_RB_LO = 3'd5;
  localparam logic [REG_AW-1:0] OFS_RB_HI = 3'd6;

  localparam int MODE_MC_REJ  = 1;
  localparam int MODE_BC_REJ  = 2;
  localparam int MODE_PROMISC = 31;
  localparam int MT_RNW_BIT   = 23;
  localparam int MT_IDX_LSB   = 16;
  localparam int RB_VALID_BIT = 31;

  typedef struct packed {
    logic promisc;
    logic bc_rej;
    logic mc_rej;
  } mode_t;
endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
  import raf_pkg::*;
#(
  parameter int AW    = 48,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output mode_t             mode,
  output logic [AW-1:0]     uc_addr,
  output logic              tbl_wr,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [AW-1:0]     tbl_wdata,
  input  logic [AW-1:0]     tbl_rdata,
  input  logic              tbl_rvalid
);
  localparam int HI_W = AW - DW;
  localparam logic [DW-1:0] MT_HI_MASK =
      (DW'(1) << MT_RNW_BIT) | (DW'((1 << IDX_W) - 1) << MT_IDX_LSB) | DW'((1 << HI_W) - 1);

  mode_t           mode_q, mode_d;
  logic [DW-1:0]   uc_lo_q, uc_lo_d;
  logic [HI_W-1:0] uc_hi_q, uc_hi_d;
  logic [DW-1:0]   mt_lo_q, mt_lo_d;
  logic [DW-1:0]   mt_hi_q, mt_hi_d;
  logic [DW-1:0]   rb_lo_q, rb_lo_d;
  logic [DW-1:0]   rb_hi_q, rb_hi_d;
  logic            mt_access, tbl_rd;

  assign mt_access = cfg_wr && (cfg_addr == OFS_MT_HI);
  assign tbl_wr    = mt_access && !cfg_wdata[MT_RNW_BIT];
  assign tbl_rd    = mt_access &&  cfg_wdata[MT_RNW_BIT];
  assign tbl_idx   = cfg_wdata[MT_IDX_LSB +: IDX_W];
  assign tbl_wdata = {cfg_wdata[HI_W-1:0], mt_lo_q};

  always_comb begin
    mode_d  = mode_q;
    uc_lo_d = uc_lo_q;
    uc_hi_d = uc_hi_q;
    mt_lo_d = mt_lo_q;
    mt_hi_d = mt_hi_q;
    rb_lo_d = rb_lo_q;
    rb_hi_d = rb_hi_q;
    if (cfg_wr) begin
      case (cfg_addr)
        OFS_MODE: begin
          mode_d.promisc = cfg_wdata[MODE_PROMISC];
          mode_d.bc_rej  = cfg_wdata[MODE_BC_REJ];
          mode_d.mc_rej  = cfg_wdata[MODE_MC_REJ];
        end
        OFS_UC_LO: uc_lo_d = cfg_wdata;
        OFS_UC_HI: uc_hi_d = cfg_wdata[HI_W-1:0];
        OFS_MT_LO: mt_lo_d = cfg_wdata;
        OFS_MT_HI: mt_hi_d = cfg_wdata & MT_HI_MASK;
        default: ;
      endcase
    end
    if (tbl_rd) begin
      rb_lo_d = tbl_rdata[DW-1:0];
      rb_hi_d = '0;
      rb_hi_d[HI_W-1:0]    = tbl_rdata[AW-1:DW];
      rb_hi_d[RB_VALID_BIT] = tbl_rvalid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      uc_lo_q <= '0;
      uc_hi_q <= '0;
      mt_lo_q <= '0;
      mt_hi_q <= '0;
      rb_lo_q <= '0;
      rb_hi_q <= '0;
    end else begin
      mode_q  <= mode_d;
      uc_lo_q <= uc_lo_d;
      uc_hi_q <= uc_hi_d;
      mt_lo_q <= mt_lo_d;
      mt_hi_q <= mt_hi_d;
      rb_lo_q <= rb_lo_d;
      rb_hi_q <= rb_hi_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      case (cfg_addr)
        OFS_MODE: begin
          cfg_rdata[MODE_PROMISC] = mode_q.promisc;
          cfg_rdata[MODE_BC_REJ]  = mode_q.bc_rej;
          cfg_rdata[MODE_MC_REJ]  = mode_q.mc_rej;
        end
        OFS_UC_LO: cfg_rdata = uc_lo_q;
        OFS_UC_HI: cfg_rdata[HI_W-1:0] = uc_hi_q;
        OFS_MT_LO: cfg_rdata = mt_lo_q;
        OFS_MT_HI: cfg_rdata = mt_hi_q;
        OFS_RB_LO: cfg_rdata = rb_lo_q;
        OFS_RB_HI: cfg_rdata = rb_hi_q;
        default:   cfg_rdata = '0;
      endcase
    end
  end

  assign mode    = mode_q;
  assign uc_addr = {uc_hi_q, uc_lo_q};
endmodule

// File: rtl/raf_mcast_table.sv
module raf_mcast_table #(
  parameter int AW        = 48,
  parameter int N_ENTRIES = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  input  logic [AW-1:0]    lookup_da,
  output logic             hit
);
  logic [AW-1:0]        ent_addr [N_ENTRIES];
  logic [N_ENTRIES-1:0] ent_vld;
  logic [N_ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic [AW-1:0] addr_q, addr_d;
    logic          vld_q, vld_d;
    logic          sel;

    assign sel = wr_en && (idx == IDX_W'(e));

    always_comb begin
      addr_d = addr_q;
      vld_d  = vld_q;
      if (sel) begin
        addr_d = wr_addr;
        vld_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        addr_q <= addr_d;
        vld_q  <= vld_d;
      end
    end

    assign ent_addr[e] = addr_q;
    assign ent_vld[e]  = vld_q;
    assign hit_vec[e]  = vld_q && (addr_q == lookup_da);
  end

  assign rd_addr  = ent_addr[idx];
  assign rd_valid = ent_vld[idx];
  assign hit      = |hit_vec;
endmodule

// File: rtl/raf_decide.sv
module raf_decide
  import raf_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  input  logic [AW-1:0] frame_da,
  input  mode_t         mode,
  input  logic [AW-1:0] uc_addr,
  input  logic          tbl_hit,
  output logic          frame_done,
  output logic          frame_accept,
  output logic          reject_evt
);
  logic is_bcast, is_uc, keep;
  logic done_q, done_d, acc_q, acc_d, rej_q, rej_d;

  assign is_bcast = &frame_da;
  assign is_uc    = (frame_da == uc_addr);
  assign keep     = mode.promisc || is_uc ||
                    (is_bcast && !mode.bc_rej) ||
                    (tbl_hit && !mode.mc_rej);

  always_comb begin
    done_d = frame_valid;
    acc_d  = acc_q;
    rej_d  = 1'b0;
    if (frame_valid) begin
      acc_d = keep;
      rej_d = !keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      acc_q  <= acc_d;
      rej_q  <= rej_d;
    end
  end

  assign frame_done   = done_q;
  assign frame_accept = acc_q;
  assign reject_evt   = rej_q;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter int AW        = 48,
  parameter int N_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              frame_valid,
  input  logic [AW-1:0]     frame_da,
  output logic              frame_done,
  output logic              frame_accept,
  output logic              reject_evt
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  mode_t            mode;
  logic [AW-1:0]    uc_addr;
  logic             tbl_wr, tbl_rvalid, tbl_hit;
  logic [IDX_W-1:0] tbl_idx;
  logic [AW-1:0]    tbl_wdata, tbl_rdata;
  logic             promisc, bc_rej, mc_rej;

  assign promisc = mode.promisc;
  assign bc_rej  = mode.bc_rej;
  assign mc_rej  = mode.mc_rej;

  raf_cfg_regs #(.AW(AW), .IDX_W(IDX_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mode       (mode),
    .uc_addr    (uc_addr),
    .tbl_wr     (tbl_wr),
    .tbl_idx    (tbl_idx),
    .tbl_wdata  (tbl_wdata),
    .tbl_rdata  (tbl_rdata),
    .tbl_rvalid (tbl_rvalid)
  );

  raf_mcast_table #(.AW(AW), .N_ENTRIES(N_ENTRIES)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr),
    .idx       (tbl_idx),
    .wr_addr   (tbl_wdata),
    .rd_addr   (tbl_rdata),
    .rd_valid  (tbl_rvalid),
    .lookup_da (frame_da),
    .hit       (tbl_hit)
  );

  raf_decide #(.AW(AW)) i_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .frame_da     (frame_da),
    .mode         (mode),
    .uc_addr      (uc_addr),
    .tbl_hit      (tbl_hit),
    .frame_done   (frame_done),
    .frame_accept (frame_accept),
    .reject_evt   (reject_evt)
  );
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_valid,
  input logic [AW-1:0] frame_da,
  input logic          frame_done,
  input logic          frame_accept,
  input logic          reject_evt,
  input logic          promisc,
  input logic          bc_rej,
  input logic          mc_rej,
  input logic [AW-1:0] uc_addr
);
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> frame_done); // R10

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(frame_valid)); // R10

  AST_REJECT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |-> (frame_done && !frame_accept)); // R10

  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && promisc) |=> frame_accept); // R4

  AST_STATION_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_da == uc_addr) |=> frame_accept); // R3

  AST_BCAST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !promisc && bc_rej && mc_rej && (&frame_da) && frame_da != uc_addr)
      |=> !frame_accept); // R5
endmodule

bind rx_addr_filter raf_checker #(.AW(AW)) i_raf_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_valid  (frame_valid),
  .frame_da     (frame_da),
  .frame_done   (frame_done),
  .frame_accept (frame_accept),
  .reject_evt   (reject_evt),
  .promisc      (promisc),
  .bc_rej       (bc_rej),
  .mc_rej       (mc_rej),
  .uc_addr      (uc_addr)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        frame_valid;
  logic [47:0] frame_da;
  logic        frame_done, frame_accept, reject_evt;

  int checks = 0;
  int fails  = 0;

  localparam logic [47:0] UC    = 48'h0605_0403_0201;
  localparam logic [47:0] GRP1  = 48'h0100_005e_0001;
  localparam logic [47:0] BCAST = 48'hffff_ffff_ffff;

  // {address, expected accept} with all reject controls off
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {UC,                 1'b1},   // R3
    {BCAST,              1'b1},   // R5
    {GRP1,               1'b1},   // R6
    {48'h0000_1122_3344, 1'b0},   // R11
    {48'h0000_0000_0003, 1'b0},   // R11
    {UC ^ 48'h1000_0000, 1'b0}    // R11
  };

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .frame_valid(frame_valid), .frame_da(frame_da), .frame_done(frame_done),
    .frame_accept(frame_accept), .reject_evt(reject_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  // Returns {done, accept, reject_evt} one cycle after the strobe, then done one cycle later
  task automatic frame(input logic [47:0] da, output logic [2:0] res, output logic done_after);
    @(negedge clk);
    frame_valid = 1'b1; frame_da = da;
    @(negedge clk);
    frame_valid = 1'b0;
    res = {frame_done, frame_accept, reject_evt};
    @(negedge clk);
    done_after = frame_done;
  endtask

  initial begin
    logic [31:0] d;
    logic [2:0]  r;
    logic        da_after;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frame_valid = 1'b0; frame_da = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check("R1 reg reset", d, 0);
    end
    check("R1 done low", {frame_done, reject_evt}, 0);
    wr(3'd4, 32'h0083_0000);        // read entry 3
    rd(3'd6, d);
    check("R1 entry invalid", d, 0);

    // R2: station address words
    wr(3'd2, 32'hABCD_0605);
    rd(3'd2, d);
    check("R2 hi masked", d, 32'h0000_0605);
    wr(3'd1, 32'h0403_0201);
    rd(3'd1, d);
    check("R2 lo", d, 32'h0403_0201);

    // R6: commit GRP1 to entry 1
    wr(3'd3, 32'h005e_0001);
    wr(3'd4, 32'h0001_0100);
    rd(3'd3, d);
    check("R8 stage lo", d, 32'h005e_0001);
    rd(3'd4, d);
    check("R8 stage hi", d, 32'h0001_0100);

    // R8: read entry 1 back, with different upper bits
    wr(3'd4, 32'h0081_ffff);
    rd(3'd5, d);
    check("R8 rb lo", d, 32'h005e_0001);
    rd(3'd6, d);
    check("R8 rb hi", d, 32'h8000_0100);
    rd(3'd4, d);
    check("R8 hi mask", d, 32'h0081_ffff);

    // vector table, all controls off
    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][48:1], r, da_after);
      check("R3/R5/R6/R11 decision", r, {1'b1, VEC[i][0], ~VEC[i][0]});
      check("R10 done single", da_after, 0);
    end

    // R5 broadcast reject, mc reject off
    wr(3'd0, 32'h0000_0004);
    rd(3'd0, d);
    check("R5 mode rb", d, 32'h4);
    frame(BCAST, r, da_after);
    check("R5 bcast dropped", r, 3'b101);
    frame(GRP1, r, da_after);
    check("R6 group kept", r, 3'b110);

    // R7 group reject
    wr(3'd0, 32'h0000_0002);
    frame(GRP1, r, da_after);
    check("R7 group dropped", r, 3'b101);
    frame(BCAST, r, da_after);
    check("R7 bcast kept", r, 3'b110);
    frame(UC, r, da_after);
    check("R3 station kept", r, 3'b110);

    // R9 all-ones entry 2
    wr(3'd3, 32'hffff_ffff);
    wr(3'd4, 32'h0002_ffff);
    wr(3'd0, 32'h0000_0004);
    frame(BCAST, r, da_after);
    check("R9 bcast via table", r, 3'b110);
    wr(3'd0, 32'h0000_0006);
    frame(BCAST, r, da_after);
    check("R5 bcast both rej", r, 3'b101);

    // R4 promiscuous
    wr(3'd0, 32'h8000_0006);
    frame(48'h0000_1122_3344, r, da_after);
    check("R4 promisc", r, 3'b110);
    check("R10 done drop", da_after, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule